// File: doc/BRIEF.md
# Partitioned Multi-Operand Add-Reduce Tree

This block adds a parameterised number of 16-bit operands into a single 16-bit result. The word can be split at run time into independent lanes: one control cuts the carry chain between bits 3 and 4, and another cuts it between bits 7 and 8. Each lane is a separate modular sum of the matching bit fields of all operands. No carry ever crosses an active cut.

The reduction is a binary tree of partition-aware two-input adders. Each tree level can hold a pipeline register, chosen by a parameter bit mask. The two split controls are registered alongside the data at every selected level. As a result, each result is formed with the lane setting that was applied together with its operands, even when the setting changes every cycle.

Top module: `lane_add_tree`

## Requirements
- R1: With `split_lo`=0 and `split_hi`=0, `sum_o` is the sum of all operands modulo 2^16.
- R2: With `split_lo`=0 and `split_hi`=1, `sum_o[15:8]` is the sum of the operands' bits 15:8 modulo 256, and `sum_o[7:0]` is the sum of their bits 7:0 modulo 256.
- R3: With `split_lo`=1 and `split_hi`=0, `sum_o[15:4]` is the sum of the operands' bits 15:4 modulo 4096, and `sum_o[3:0]` is the sum of their bits 3:0 modulo 16.
- R4: With both controls set to 1, the fields 15:8, 7:4 and 3:0 of `sum_o` are each the modular sum of the same field across all operands.
- R5: Bit l of `REG_LEVELS` inserts a register at tree level l. Level 0 holds the operands. Level l≥1 holds the outputs of the l-th adder layer. Only levels 0 to ceil(log2(N_IN)) count, and bits above that are ignored. The latency in cycles equals the number of counted set bits. With no counted bit set, the block is purely combinational.
- R6: The split controls travel through the pipeline with the operands. With a different setting on every cycle, each result follows the setting applied with its own operands.
- R7: With `N_IN`=0, `sum_o` is always zero.
- R8: While `rst_n` is low, every pipeline register clears, so a pipelined instance drives `sum_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_lo | input | 1 | 1 blocks the carry from bit 3 into bit 4 |
| split_hi | input | 1 | 1 blocks the carry from bit 7 into bit 8 |
| ops_i | input | max(N_IN,1)*16 | Operands, operand k at bits 16k+15:16k |
| sum_o | output | 16 | Lane-wise reduced sum |

## Verification
On every cycle, assertions check each two-input adder in the tree. Under each of the four split settings, every lane of its result must equal the modular sum of that lane's input fields. An instance with no operands is also checked to hold its output at zero. End-to-end lane sums, the latency set by the level mask, the mask bits that are ignored, the controls staying aligned with data across a stream of changing settings, and the cleared output under reset can only be shown by the bench's streaming scenarios. These scenarios compare the outputs of a pipelined, a combinational and an empty instance against lane arithmetic computed in the bench.

// File: rtl/lane_add_pkg.sv
package lane_add_pkg;

    localparam int W      = 16;  // operand and result width
    localparam int CUT_LO = 4;   // first bit of the lane above the low cut
    localparam int CUT_HI = 8;   // first bit of the lane above the high cut

    // number of values alive at tree level lvl when n values enter
    function automatic int slot_count(input int n, input int lvl);
        return (n + (1 << lvl) - 1) >> lvl;
    endfunction

endpackage

// File: rtl/lane_add_cell.sv
module lane_add_cell
    import lane_add_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         split_lo,
    input  logic         split_hi,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);

    // ripple adder whose carry is killed at each active cut
    always_comb begin
        logic cy;
        cy = 1'b0;
        for (int i = 0; i < W; i++) begin
            if ((i == CUT_LO && split_lo) || (i == CUT_HI && split_hi))
                cy = 1'b0;
            sum_o[i] = a_i[i] ^ b_i[i] ^ cy;
            cy = (a_i[i] & b_i[i]) | (cy & (a_i[i] ^ b_i[i]));
        end
    end

    AST_WHOLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_lo && !split_hi) |-> (sum_o == a_i + b_i)); // R1

    AST_BYTE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_lo && split_hi) |->
            ((sum_o[W-1:CUT_HI] == a_i[W-1:CUT_HI] + b_i[W-1:CUT_HI]) &&
             (sum_o[CUT_HI-1:0] == a_i[CUT_HI-1:0] + b_i[CUT_HI-1:0]))); // R2

    AST_NIBBLE_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (split_lo && !split_hi) |->
            ((sum_o[W-1:CUT_LO] == a_i[W-1:CUT_LO] + b_i[W-1:CUT_LO]) &&
             (sum_o[CUT_LO-1:0] == a_i[CUT_LO-1:0] + b_i[CUT_LO-1:0]))); // R3

    AST_THREE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (split_lo && split_hi) |->
            ((sum_o[W-1:CUT_HI] == a_i[W-1:CUT_HI] + b_i[W-1:CUT_HI]) &&
             (sum_o[CUT_HI-1:CUT_LO] == a_i[CUT_HI-1:CUT_LO] + b_i[CUT_HI-1:CUT_LO]) &&
             (sum_o[CUT_LO-1:0] == a_i[CUT_LO-1:0] + b_i[CUT_LO-1:0]))); // R4

endmodule

// File: rtl/lane_add_layer.sv
module lane_add_layer
    import lane_add_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         split_lo,
    input  logic                         split_hi,
    input  logic [N_SRC*W-1:0]           src_i,
    output logic [((N_SRC+1)/2)*W-1:0]   dst_o
);

    localparam int N_PAIR = N_SRC / 2;
    localparam bit ODD    = (N_SRC % 2) == 1;

    for (genvar j = 0; j < N_PAIR; j++) begin : g_pair
        lane_add_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .split_lo (split_lo),
            .split_hi (split_hi),
            .a_i      (src_i[(2*j)*W +: W]),
            .b_i      (src_i[(2*j+1)*W +: W]),
            .sum_o    (dst_o[j*W +: W])
        );
    end

    // an operand without a partner moves up one level unchanged
    if (ODD) begin : g_carry_up
        assign dst_o[N_PAIR*W +: W] = src_i[(N_SRC-1)*W +: W];
    end

endmodule

// File: rtl/lane_add_stage.sv
module lane_add_stage #(
    parameter int BITS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] d_i,
    input  logic            lo_i,
    input  logic            hi_i,
    output logic [BITS-1:0] q_o,
    output logic            lo_o,
    output logic            hi_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o  <= '0;
            lo_o <= 1'b0;
            hi_o <= 1'b0;
        end else begin
            q_o  <= d_i;
            lo_o <= lo_i;
            hi_o <= hi_i;
        end
    end

endmodule

// File: rtl/lane_add_tree.sv
module lane_add_tree
    import lane_add_pkg::*;
#(
    parameter int       N_IN       = 5,
    parameter bit [7:0] REG_LEVELS = 8'b0001_0101
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 split_lo,
    input  logic                                 split_hi,
    input  logic [((N_IN > 0) ? N_IN : 1)*W-1:0] ops_i,
    output logic [W-1:0]                         sum_o
);

    localparam int SLOTS   = (N_IN > 0) ? N_IN : 1;
    localparam int TOP_LEV = $clog2(SLOTS);

    for (genvar l = 0; l <= TOP_LEV; l++) begin : g_lv
        localparam int CNT = slot_count(SLOTS, l);
        logic [CNT*W-1:0] raw;
        logic [CNT*W-1:0] q;
        logic             raw_lo, raw_hi, q_lo, q_hi;

        if (l == 0) begin : g_src
            assign raw    = (N_IN == 0) ? '0 : ops_i;
            assign raw_lo = split_lo;
            assign raw_hi = split_hi;
        end else begin : g_sum
            lane_add_layer #(.N_SRC(slot_count(SLOTS, l - 1))) u_layer (
                .clk      (clk),
                .rst_n    (rst_n),
                .split_lo (g_lv[l-1].q_lo),
                .split_hi (g_lv[l-1].q_hi),
                .src_i    (g_lv[l-1].q),
                .dst_o    (raw)
            );
            assign raw_lo = g_lv[l-1].q_lo;
            assign raw_hi = g_lv[l-1].q_hi;
        end

        if (REG_LEVELS[l]) begin : g_reg
            lane_add_stage #(.BITS(CNT*W)) u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (raw),
                .lo_i  (raw_lo),
                .hi_i  (raw_hi),
                .q_o   (q),
                .lo_o  (q_lo),
                .hi_o  (q_hi)
            );
        end else begin : g_wire
            assign q    = raw;
            assign q_lo = raw_lo;
            assign q_hi = raw_hi;
        end
    end

    assign sum_o = g_lv[TOP_LEV].q;

    if (N_IN == 0) begin : g_empty_chk
        AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            sum_o == '0); // R7
    end

endmodule

// File: tb/lane_add_tree_tb.sv
module lane_add_tree_tb;

    localparam int W     = 16;
    localparam int ND    = 5;   // pipelined instance: levels 0,2 counted, 4 ignored
    localparam int LAT_D = 2;
    localparam int NC    = 3;   // combinational instance

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic split_lo = 1'b0;
    logic split_hi = 1'b0;
    logic [ND*W-1:0] ops_d = '0;
    logic [NC*W-1:0] ops_c = '0;
    logic [W-1:0]    ops_z = '0;
    logic [W-1:0]    out_d, out_c, out_z;

    int checks = 0;
    int errors = 0;
    int k = 0;
    logic [W-1:0] exp_d [0:1023];
    string        tag_d [0:1023];
    logic [31:0]  rng = 32'h1357_9bdf;

    always #4 clk = ~clk;

    lane_add_tree #(.N_IN(ND), .REG_LEVELS(8'b0001_0101)) u_dut (
        .clk(clk), .rst_n(rst_n), .split_lo(split_lo), .split_hi(split_hi),
        .ops_i(ops_d), .sum_o(out_d));

    lane_add_tree #(.N_IN(NC), .REG_LEVELS(8'h00)) u_comb (
        .clk(clk), .rst_n(rst_n), .split_lo(split_lo), .split_hi(split_hi),
        .ops_i(ops_c), .sum_o(out_c));

    lane_add_tree #(.N_IN(0), .REG_LEVELS(8'h01)) u_zero (
        .clk(clk), .rst_n(rst_n), .split_lo(split_lo), .split_hi(split_hi),
        .ops_i(ops_z), .sum_o(out_z));

    function automatic logic [W-1:0] model(input logic [ND*W-1:0] ops, input int n,
                                           input bit lo, input bit hi);
        logic [W-1:0] y;
        logic [W-1:0] m;
        logic [31:0]  s;
        int           base;
        y = '0;
        base = 0;
        for (int top = 1; top <= W; top++) begin
            if (top == W || (top == 4 && lo) || (top == 8 && hi)) begin
                m = (16'hFFFF >> (W - (top - base))) << base;
                s = '0;
                for (int j = 0; j < n; j++) s += 32'(ops[j*W +: W] & m);
                y |= s[W-1:0] & m;
                base = top;
            end
        end
        return y;
    endfunction

    function automatic string lane_tag(input bit lo, input bit hi);
        if (!lo && !hi) return "R1";
        if (!lo && hi)  return "R2";
        if (lo && !hi)  return "R3";
        return "R4";
    endfunction

    task automatic rand32(output logic [31:0] v);
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        v = rng;
    endtask

    task automatic rand_vec(output logic [ND*W-1:0] v);
        logic [31:0] r;
        for (int j = 0; j < ND; j++) begin
            rand32(r);
            v[j*W +: W] = r[W-1:0] ^ r[31:W];
        end
    endtask

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    // one negedge: check the result due now, then apply the next vector
    task automatic step(input logic [ND*W-1:0] v, input bit lo, input bit hi, input string tag);
        @(negedge clk);
        if (k >= LAT_D) check(tag_d[k-LAT_D], out_d, exp_d[k-LAT_D]);
        else            check("R5 latency", out_d, '0);
        check("R7", out_z, '0);
        ops_d    = v;
        ops_c    = v[NC*W-1:0];
        ops_z    = v[W-1:0];
        split_lo = lo;
        split_hi = hi;
        exp_d[k] = model(v, ND, lo, hi);
        tag_d[k] = tag;
        k++;
        #1;
        check({"R5 comb ", tag}, out_c, model({{(ND-NC)*W{1'b0}}, v[NC*W-1:0]}, NC, lo, hi));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [ND*W-1:0] v;
        // R8: registers held clear while reset is low, inputs busy
        rand_vec(v);
        ops_d = v;
        ops_z = v[W-1:0];
        split_lo = 1'b1;
        repeat (3) @(negedge clk);
        check("R8", out_d, '0);
        check("R8 empty", out_z, '0);
        rst_n    = 1'b1;
        ops_d    = '0;
        ops_z    = '0;
        split_lo = 1'b0;
        repeat (3) @(negedge clk);

        // sweep all four lane settings with corner and random vectors
        for (int s = 0; s < 4; s++) begin
            step({ND{16'hFFFF}}, s[0], s[1], lane_tag(s[0], s[1]));
            step({ND{16'h8888}}, s[0], s[1], lane_tag(s[0], s[1]));
            step({ND{16'h0F0F}}, s[0], s[1], lane_tag(s[0], s[1]));
            step({ND{16'h7FF7}}, s[0], s[1], lane_tag(s[0], s[1]));
            for (int i = 0; i < 48; i++) begin
                rand_vec(v);
                step(v, s[0], s[1], lane_tag(s[0], s[1]));
            end
        end

        // R6: setting changes on every cycle of a continuous stream
        for (int i = 0; i < 64; i++) begin
            logic [31:0] r;
            rand32(r);
            rand_vec(v);
            step(v, r[7], r[19], "R6");
        end

        // drain the pipeline
        for (int i = 0; i < LAT_D; i++) step('0, 1'b0, 1'b0, "R1");
        @(negedge clk);
        check(tag_d[k-LAT_D], out_d, exp_d[k-LAT_D]);
        finish_run();
    end

endmodule